// File: doc/BRIEF.md
# Fall-Through Handshake FIFO

This block is a small first-in first-out store in which every word travels toward the output on its own, one register stage at a time. There is no read pointer and no write pointer. Each stage is a data register with a valid bit. A word moves forward on a clock when its stage is occupied and the next stage is empty.

Both sides use strobe handshakes, and a single system clock samples both strobes. A writer waits for the input-ready flag, puts a word on the input bus and raises the shift-in strobe. Only the low-to-high transition of that strobe counts. A reader waits for the output-ready flag and takes the word shown on the output bus. It then raises the shift-out strobe to discard that word. A synchronous, active-high master reset empties the store.

The width and the number of stages are parameters. The defaults are 4 bits and 16 words.

Top module: `ripple_fifo`

## Requirements
- R1: On the clock after `rst` is sampled high, `in_ready` is 1 and `out_ready` is 0, and no word from before the reset is ever presented.
- R2: A word is written only at a clock edge where `shift_in` is sampled 1, `shift_in` was sampled 0 at the previous edge, and `in_ready` is 1. The value of `data_in` at that edge is stored.
- R3: After an accepted write, `in_ready` is 0 for the next clock. It returns to 1 one clock later, when the second stage was free.
- R4: If `shift_in` is held high for any number of clocks, exactly one word is written.
- R5: If a word is written into an empty store at edge k, `out_ready` rises at edge k+DEPTH-1 and `data_out` carries that word.
- R6: While `out_ready` is 1 and no read is strobed, `out_ready` stays 1 and `data_out` stays unchanged.
- R7: A rising `shift_out` sampled while `out_ready` is 1 removes the presented word, and `out_ready` is 0 on the next clock.
- R8: Words leave in exactly the order in which they were written.
- R9: The store holds exactly DEPTH words. When it is full, `in_ready` stays 0, and a further strobe adds no word.
- R10: A rising `shift_out` while `out_ready` is 0 has no effect. A word written later is still delivered.
- R11: If `shift_in` is high when reset ends, it must be seen low before any word is written.
- R12: A write and a read whose strobes rise at the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples both strobes |
| rst | input | 1 | Synchronous active-high master reset |
| shift_in | input | 1 | Write strobe; the rising transition writes a word |
| data_in | input | WIDTH | Word to be written |
| in_ready | output | 1 | High when the first stage can accept a word |
| shift_out | input | 1 | Read strobe; the rising transition discards the presented word |
| out_ready | output | 1 | High when the last stage holds a word |
| data_out | output | WIDTH | Oldest stored word |

## Verification
A write and a read can both take effect at the same clock edge. At that edge, the first stage fills while the last stage empties. The bench provokes this case by leaving one word at the output with the first stage free, and then raising both strobes on the same falling edge. It judges the result on the next clock: `in_ready` and `out_ready` must both be low, and the scoreboard must later receive the new word in order. Randomly timed writer and reader threads repeat the overlap many times, and the reference queue checks the order of every word.

// File: rtl/ripple_fifo_pkg.sv
package ripple_fifo_pkg;
  localparam int unsigned DEF_WIDTH = 4;
  localparam int unsigned DEF_DEPTH = 16;
endpackage

// File: rtl/strobe_rise.sv
// Detects the low-to-high transition of a strobe sampled by clk.
// The history bit is reset to 1, so a strobe that is still high
// after reset must first be seen low.
module strobe_rise (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b1;
    else     level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/ripple_stage.sv
// One storage stage: a valid bit and a data register.
module ripple_stage #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             give,
  input  logic [WIDTH-1:0] d,
  output logic             vld,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       vld <= 1'b0;
    else if (take) vld <= 1'b1;
    else if (give) vld <= 1'b0;
  end

  // The data register has no reset, so it maps to plain flops.
  always_ff @(posedge clk) begin
    if (take) q <= d;
  end
endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo
  import ripple_fifo_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  parameter int unsigned DEPTH = DEF_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] data_in,
  output logic             in_ready,
  input  logic             shift_out,
  output logic             out_ready,
  output logic [WIDTH-1:0] data_out
);
  localparam int unsigned LAST = DEPTH - 1;

  logic             wr_rise, rd_rise;
  logic             push, pop;
  logic [DEPTH-1:0] stage_vld;
  logic [DEPTH-1:0] take;
  logic [DEPTH-1:0] give;
  logic [WIDTH-1:0] stage_q [DEPTH];

  strobe_rise u_wr_edge (.clk(clk), .rst(rst), .level(shift_in),  .rise(wr_rise));
  strobe_rise u_rd_edge (.clk(clk), .rst(rst), .level(shift_out), .rise(rd_rise));

  assign push = wr_rise & ~stage_vld[0];
  assign pop  = rd_rise & stage_vld[LAST];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [WIDTH-1:0] d_src;

    if (i == 0) begin : g_head
      assign take[i] = push;
      assign d_src   = data_in;
    end else begin : g_body
      assign take[i] = give[i-1];
      assign d_src   = stage_q[i-1];
    end

    if (i == LAST) begin : g_tail
      assign give[i] = pop;
    end else begin : g_move
      assign give[i] = stage_vld[i] & ~stage_vld[i+1];
    end

    ripple_stage #(.WIDTH(WIDTH)) u_stage (
      .clk (clk),
      .rst (rst),
      .take(take[i]),
      .give(give[i]),
      .d   (d_src),
      .vld (stage_vld[i]),
      .q   (stage_q[i])
    );
  end

  // All three outputs come straight from stage registers.
  assign in_ready  = ~stage_vld[0];
  assign out_ready = stage_vld[LAST];
  assign data_out  = stage_q[LAST];
endmodule

// File: rtl/ripple_fifo_check.sv
module ripple_fifo_check #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned DEPTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             shift_in,
  input logic             shift_out,
  input logic             in_ready,
  input logic             out_ready,
  input logic [WIDTH-1:0] data_out,
  input logic [DEPTH-1:0] vld
);
  logic si_prev, so_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      si_prev <= 1'b1;
      so_prev <= 1'b1;
    end else begin
      si_prev <= shift_in;
      so_prev <= shift_out;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (in_ready && !out_ready));

  assert_ready_dip_R3: assert property (@(posedge clk) disable iff (rst)
    (in_ready && shift_in && !si_prev) |=> !in_ready);

  assert_held_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    (shift_in && si_prev) |=> ($countones(vld) <= $past($countones(vld))));

  assert_output_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_ready && !shift_out) |=> (out_ready && $stable(data_out)));

  assert_pop_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (out_ready && shift_out && !so_prev) |=> !out_ready);
endmodule

bind ripple_fifo ripple_fifo_check #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_check (
  .clk      (clk),
  .rst      (rst),
  .shift_in (shift_in),
  .shift_out(shift_out),
  .in_ready (in_ready),
  .out_ready(out_ready),
  .data_out (data_out),
  .vld      (stage_vld)
);

// File: tb/ripple_fifo_test.sv
module ripple_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH = 4;
  localparam int DEPTH = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             shift_in = 1'b0;
  logic             shift_out = 1'b0;
  logic [WIDTH-1:0] data_in = '0;
  logic             in_ready, out_ready;
  logic [WIDTH-1:0] data_out;

  int checks = 0;
  int failures = 0;
  logic [WIDTH-1:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ripple_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .shift_in(shift_in), .data_in(data_in),
    .in_ready(in_ready), .shift_out(shift_out),
    .out_ready(out_ready), .data_out(data_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Driver: waits for in_ready, strobes once and records the expected word.
  task automatic wr(input logic [WIDTH-1:0] d);
    do @(negedge clk); while (!in_ready);
    data_in  = d;
    shift_in = 1'b1;
    exp_q.push_back(d);
    @(negedge clk);
    shift_in = 1'b0;
  endtask

  // Monitor side: compares the presented word with the queue head, then discards it.
  task automatic rd(input string req);
    logic [WIDTH-1:0] e;
    do @(negedge clk); while (!out_ready);
    e = exp_q.pop_front();
    check(data_out == e, req, int'(data_out), int'(e));
    shift_out = 1'b1;
    @(negedge clk);
    check(out_ready == 1'b0, "R7", int'(out_ready), 0);
    shift_out = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 and R11: the strobe is held high across the end of reset.
    shift_in = 1'b1;
    data_in  = 4'h9;
    cycles(3);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", int'(in_ready), 1);
    check(out_ready == 1'b0, "R1", int'(out_ready), 0);
    cycles(25);
    check(out_ready == 1'b0, "R11", int'(out_ready), 0);
    check(in_ready == 1'b1, "R11", int'(in_ready), 1);
    shift_in = 1'b0;
    cycles(2);

    // R2, R3, R5, R6: one word falls through an empty store.
    data_in  = 4'hA;
    shift_in = 1'b1;
    exp_q.push_back(4'hA);
    @(negedge clk);
    shift_in = 1'b0;
    data_in  = 4'h3;
    check(in_ready == 1'b0, "R3", int'(in_ready), 0);
    @(negedge clk);
    check(in_ready == 1'b1, "R3", int'(in_ready), 1);
    cycles(DEPTH - 3);
    check(out_ready == 1'b0, "R5", int'(out_ready), 0);
    @(negedge clk);
    check(out_ready == 1'b1, "R5", int'(out_ready), 1);
    check(data_out == 4'hA, "R2", int'(data_out), 10);
    cycles(6);
    check(out_ready == 1'b1 && data_out == 4'hA, "R6", int'(data_out), 10);
    rd("R5");

    // R10: a read strobe on an empty store has no effect.
    shift_out = 1'b1;
    @(negedge clk);
    shift_out = 1'b0;
    @(negedge clk);
    check(out_ready == 1'b0, "R10", int'(out_ready), 0);
    wr(4'h5);
    rd("R10");

    // R4: a held strobe writes one word only.
    data_in  = 4'hC;
    shift_in = 1'b1;
    exp_q.push_back(4'hC);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      data_in = WIDTH'(i);
    end
    shift_in = 1'b0;
    rd("R4");
    cycles(DEPTH + 4);
    check(out_ready == 1'b0, "R4", int'(out_ready), 0);

    // R9: the capacity is exactly DEPTH words.
    for (int i = 0; i < DEPTH; i++) wr(WIDTH'(i + 1));
    cycles(DEPTH + 4);
    check(in_ready == 1'b0, "R9", int'(in_ready), 0);
    data_in  = 4'hF;
    shift_in = 1'b1;
    @(negedge clk);
    shift_in = 1'b0;
    cycles(3);
    for (int i = 0; i < DEPTH; i++) rd("R9");
    cycles(DEPTH + 4);
    check(out_ready == 1'b0, "R9", int'(out_ready), 0);

    // R12: a write and a read at the same edge.
    wr(4'h6);
    cycles(DEPTH + 2);
    check(out_ready == 1'b1 && in_ready == 1'b1, "R12", int'(out_ready), 1);
    data_in   = 4'h7;
    shift_in  = 1'b1;
    shift_out = 1'b1;
    exp_q.push_back(4'h7);
    check(data_out == 4'h6, "R12", int'(data_out), 6);
    void'(exp_q.pop_front());
    @(negedge clk);
    check(out_ready == 1'b0, "R12", int'(out_ready), 0);
    check(in_ready == 1'b0, "R12", int'(in_ready), 0);
    shift_in  = 1'b0;
    shift_out = 1'b0;
    rd("R12");

    // R8: random bursts and random read gaps.
    fork
      begin
        for (int b = 0; b < 12; b++) begin
          for (int k = 0; k < 6; k++) wr(WIDTH'($urandom_range(0, 15)));
          cycles($urandom_range(0, 30));
        end
      end
      begin
        for (int n = 0; n < 72; n++) begin
          rd("R8");
          cycles($urandom_range(0, 5));
        end
      end
    join
    check(exp_q.size() == 0, "R8", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule